// File: doc/BRIEF.md
# Packet End Gap Detector

This block decides when a burst of edges on a monitored line has finished, or when the wait for it has run too long. A request carries three values: which channel to watch, the smallest edge count that qualifies as a packet, and a time limit in microseconds. When the request is accepted, the block records the selected channel's current write position in an edge-capture ring. After that it follows the position and a one-cycle microsecond strobe.

On every strobe the block first checks the elapsed time against the limit. If the limit is not yet exceeded, it measures how far the ring position has moved since the last point of activity. A move of more than three edges marks the line as active: the activity point and its time are updated, and the move is added to a running edge total. A smaller move counts as quiet. The burst is over when the line has been quiet for more than twenty microseconds and the running total, less a noise allowance of one edge per 256 microseconds of elapsed time, still reaches the requested minimum. A requested minimum of zero turns off burst detection, so only the time limit can end the wait.

The FSM has three states. IDLE waits for a request. WATCH evaluates on each strobe. DONE lasts one cycle and raises the done pulse. The transitions are: accept (IDLE to WATCH on a start request), expire (WATCH to DONE when the elapsed time passes the limit), settle (WATCH to DONE when the end-of-burst rule holds), and release (DONE to IDLE, always).

Top module: `pegd_gap_detector`

## Requirements
- R1: After reset, busy_o, done_o and timed_out_o are all 0.
- R2: A start_i seen in IDLE is accepted at that clock edge, and busy_o is 1 from the next cycle. Time counts only strobes that arrive after acceptance, so a strobe in the accepting cycle is not counted.
- R3: On the strobe whose count since acceptance exceeds timeout_us_i, the block enters DONE with timed_out_o=1. For a limit L this is strobe L+1.
- R4: When min_edges_i is 0, edges never end the wait. Only the time limit does, and it always ends with timed_out_o=1.
- R5: A strobe on which the ring has advanced by more than 3 since the last activity point is activity. It moves the activity point and time and adds the advance to the total. An advance of exactly 3 or less leaves all three unchanged, so small advances build up against the old point.
- R6: On a quiet strobe at time t (counted in strobes), with last activity at time g (0 at acceptance), the block enters DONE with timed_out_o=0 when t-g>20 and total-floor(t/256) >= min_edges_i.
- R7: The noise allowance floor(t/256) is subtracted from the total, so a burst that is enough early in the wait can fall short later.
- R8: Ring advances are taken modulo 960: a position moving from 955 by 10 edges reads 5 and counts as 10.
- R9: done_o is high for exactly one cycle. timed_out_o keeps its value until the next accepted start, which clears it.
- R10: start_i is ignored while busy_o is 1, including the DONE cycle.
- R11: chan_i selects field chan_i of edge_pos_i (bits [10*c+9:10*c]). Movement on the other field has no effect.
- R12: When the time limit and the end-of-burst rule are both met on the same strobe, the timeout takes priority and timed_out_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a wait |
| chan_i | input | 1 | Channel to watch |
| min_edges_i | input | 16 | Minimum edge count for a packet; 0 means time limit only |
| timeout_us_i | input | 20 | Time limit in microsecond strobes |
| us_tick_i | input | 1 | One-cycle strobe, once per microsecond |
| edge_pos_i | input | 20 | Ring write position of each channel, 10 bits each |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| timed_out_o | output | 1 | Last operation ended on the time limit |

## Verification
The bench targets the exact busy threshold: an advance of three must not count as activity, while two advances of two (four in total) must. A design that compared with three inclusively would end a near-silent wait early. It checks that the noise allowance turns a marginal late burst into a timeout, and a ring position wrapping past 959, which a plain subtraction would read as a huge or negative advance. It also checks a strobe on which both the limit and the quiet gap are met, a restart request issued mid-wait that a careless FSM would take, and a strobe in the accepting cycle that would make every completion one strobe early if it were counted.

// File: rtl/pegd_pkg.sv
package pegd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_DONE  = 2'd2
    } pegd_state_e;
endpackage

// File: rtl/pegd_chan_mux.sv
module pegd_chan_mux #(
    parameter int CHANNELS = 2,
    parameter int POS_W    = 10,
    parameter int CH_W     = 1
) (
    input  logic [CHANNELS*POS_W-1:0] pos_flat_i,
    input  logic [CH_W-1:0]           sel_i,
    output logic [POS_W-1:0]          pos_o
);
    logic [POS_W-1:0] lanes [CHANNELS];

    for (genvar g = 0; g < CHANNELS; g++) begin : g_lane
        assign lanes[g] = pos_flat_i[g*POS_W +: POS_W];
    end

    assign pos_o = lanes[sel_i];
endmodule

// File: rtl/pegd_ring_delta.sv
module pegd_ring_delta #(
    parameter int DEPTH       = 960,
    parameter int POS_W       = 10,
    parameter int BUSY_THRESH = 3
) (
    input  logic [POS_W-1:0] cur_i,
    input  logic [POS_W-1:0] base_i,
    output logic [POS_W-1:0] delta_o,
    output logic             active_o
);
    localparam logic [POS_W-1:0] DEPTH_LO = POS_W'(DEPTH);

    logic [POS_W-1:0] raw;

    always_comb begin
        raw = cur_i - base_i;
        if (cur_i >= base_i) begin
            delta_o = raw;
        end else begin
            delta_o = raw + DEPTH_LO;
        end
        active_o = delta_o > POS_W'(BUSY_THRESH);
    end

    // R8: an advance between two in-ring positions stays inside the ring
    always_comb begin
        if (32'(cur_i) < DEPTH && 32'(base_i) < DEPTH) begin
            a_r8_delta_in_ring: assert (32'(delta_o) < DEPTH);
        end
    end
endmodule

// File: rtl/pegd_end_judge.sv
module pegd_end_judge #(
    parameter int TIME_W      = 20,
    parameter int TOTAL_W     = 24,
    parameter int EDGE_W      = 16,
    parameter int QUIET_US    = 20,
    parameter int NOISE_SHIFT = 8
) (
    input  logic [TIME_W:0]    t_now_i,
    input  logic [TIME_W:0]    t_gap_i,
    input  logic [TOTAL_W-1:0] total_i,
    input  logic [EDGE_W-1:0]  min_edges_i,
    output logic               quiet_o,
    output logic               count_o
);
    localparam int CMP_W = ((TOTAL_W > TIME_W + 1) ? TOTAL_W : TIME_W + 1) + 2;

    logic [TIME_W:0]  since_gap;
    logic [CMP_W-1:0] need;

    always_comb begin
        since_gap = t_now_i - t_gap_i;
        quiet_o   = since_gap > (TIME_W+1)'(QUIET_US);
        need      = CMP_W'(min_edges_i) + CMP_W'(t_now_i >> NOISE_SHIFT);
        count_o   = CMP_W'(total_i) >= need;
    end
endmodule

// File: rtl/pegd_gap_detector.sv
module pegd_gap_detector
    import pegd_pkg::*;
#(
    parameter int CHANNELS    = 2,
    parameter int BUF_DEPTH   = 960,
    parameter int EDGE_W      = 16,
    parameter int TIME_W      = 20,
    parameter int TOTAL_W     = 24,
    parameter int BUSY_THRESH = 3,
    parameter int QUIET_US    = 20,
    parameter int NOISE_SHIFT = 8,
    localparam int POS_W      = $clog2(BUF_DEPTH),
    localparam int CH_W       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [CH_W-1:0]           chan_i,
    input  logic [EDGE_W-1:0]         min_edges_i,
    input  logic [TIME_W-1:0]         timeout_us_i,
    input  logic                      us_tick_i,
    input  logic [CHANNELS*POS_W-1:0] edge_pos_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      timed_out_o
);
    pegd_state_e        state_q, state_d;
    logic [CH_W-1:0]    chan_q;
    logic [EDGE_W-1:0]  min_q;
    logic [TIME_W-1:0]  limit_q;
    logic [TIME_W:0]    elapsed_q, gap_t_q, t_next;
    logic [POS_W-1:0]   base_q;
    logic [TOTAL_W-1:0] total_q;
    logic               to_q;

    logic [CH_W-1:0]    sel;
    logic [POS_W-1:0]   pos_sel, delta;
    logic               active, quiet, count_ok, over_limit, gap_mode;
    logic [TOTAL_W:0]   tot_sum;
    logic               accept, expire, settle;

    assign sel = (state_q == ST_IDLE) ? chan_i : chan_q;

    pegd_chan_mux #(.CHANNELS(CHANNELS), .POS_W(POS_W), .CH_W(CH_W)) u_mux (
        .pos_flat_i (edge_pos_i),
        .sel_i      (sel),
        .pos_o      (pos_sel)
    );

    pegd_ring_delta #(.DEPTH(BUF_DEPTH), .POS_W(POS_W), .BUSY_THRESH(BUSY_THRESH)) u_delta (
        .cur_i    (pos_sel),
        .base_i   (base_q),
        .delta_o  (delta),
        .active_o (active)
    );

    assign t_next     = elapsed_q + {{TIME_W{1'b0}}, 1'b1};
    assign over_limit = t_next > {1'b0, limit_q};
    assign gap_mode   = |min_q;
    assign tot_sum    = {1'b0, total_q} + (TOTAL_W+1)'(delta);

    pegd_end_judge #(
        .TIME_W(TIME_W), .TOTAL_W(TOTAL_W), .EDGE_W(EDGE_W),
        .QUIET_US(QUIET_US), .NOISE_SHIFT(NOISE_SHIFT)
    ) u_judge (
        .t_now_i     (t_next),
        .t_gap_i     (gap_t_q),
        .total_i     (total_q),
        .min_edges_i (min_q),
        .quiet_o     (quiet),
        .count_o     (count_ok)
    );

    // transition conditions
    assign accept = (state_q == ST_IDLE) && start_i;
    assign expire = (state_q == ST_WATCH) && us_tick_i && over_limit;
    assign settle = (state_q == ST_WATCH) && us_tick_i && !over_limit &&
                    gap_mode && !active && quiet && count_ok;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_WATCH;
            ST_WATCH: if (expire || settle) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and per-tick bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q    <= '0;
            min_q     <= '0;
            limit_q   <= '0;
            elapsed_q <= '0;
            gap_t_q   <= '0;
            base_q    <= '0;
            total_q   <= '0;
            to_q      <= 1'b0;
        end else if (accept) begin
            chan_q    <= chan_i;
            min_q     <= min_edges_i;
            limit_q   <= timeout_us_i;
            elapsed_q <= '0;
            gap_t_q   <= '0;
            base_q    <= pos_sel;
            total_q   <= '0;
            to_q      <= 1'b0;
        end else if (state_q == ST_WATCH && us_tick_i) begin
            elapsed_q <= t_next;
            if (over_limit) begin
                to_q <= 1'b1;
            end else if (gap_mode && active) begin
                gap_t_q <= t_next;
                base_q  <= pos_sel;
                total_q <= tot_sum[TOTAL_W] ? {TOTAL_W{1'b1}} : tot_sum[TOTAL_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        timed_out_o = to_q;
    end

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: the result flag only changes on an accepted start or in WATCH
    a_r9_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> $stable(timed_out_o));
    // R3: a timeout is flagged only once elapsed time passes the limit
    a_r3_flag_after_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timed_out_o) |-> (elapsed_q > {1'b0, limit_q}));
    // R6: a burst end happens inside the limit
    a_r6_settle_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !timed_out_o) |-> (elapsed_q <= {1'b0, limit_q}));
    // R4: a zero minimum only ever ends on the limit
    a_r4_zero_min_times_out: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && min_q == '0) |-> timed_out_o);
    // R10: captured request stays put while busy
    a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(limit_q) && $stable(min_q) && $stable(chan_q)));
    // R5: the running total never decreases within a wait
    a_r5_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH) |=> (total_q >= $past(total_q)));
endmodule

// File: tb/pegd_gap_detector_tb.sv
module pegd_gap_detector_tb;
    localparam int DEPTH = 960;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [0:0]  chan_i = '0;
    logic [15:0] min_edges_i = '0;
    logic [19:0] timeout_us_i = '0;
    logic        us_tick_i = 1'b0;
    logic [19:0] edge_pos_i;
    logic        busy_o, done_o, timed_out_o;

    int p0 = 0, p1 = 0;
    assign edge_pos_i = {p1[9:0], p0[9:0]};

    always #2 clk = ~clk;

    pegd_gap_detector u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .min_edges_i(min_edges_i), .timeout_us_i(timeout_us_i),
        .us_tick_i(us_tick_i), .edge_pos_i(edge_pos_i),
        .busy_o(busy_o), .done_o(done_o), .timed_out_o(timed_out_o)
    );

    int errors = 0, checks = 0, cycles = 0;
    string cur_req = "R1";
    int ticks = 0, done_tick = -1;
    bit saw_done = 0, done_to = 0;

    // behavioural reference: 0 idle, 1 watching, 2 done
    int m_st = 0, m_ch = 0, m_min = 0, m_lim = 0, m_el = 0, m_gap = 0, m_base = 0, m_tot = 0;
    bit m_to = 0;

    always @(posedge clk) begin
        int pos, t, d;
        if (!rst_n) begin
            m_st = 0; m_to = 0;
        end else begin
            case (m_st)
                0: if (start_i) begin
                    m_ch = chan_i; m_min = min_edges_i; m_lim = timeout_us_i;
                    m_base = m_ch ? p1 : p0; m_el = 0; m_gap = 0; m_tot = 0; m_to = 0;
                    m_st = 1;
                end
                1: if (us_tick_i) begin
                    pos = m_ch ? p1 : p0;
                    t = m_el + 1; m_el = t;
                    if (t > m_lim) begin
                        m_to = 1; m_st = 2;
                    end else if (m_min != 0) begin
                        d = (pos - m_base + DEPTH) % DEPTH;
                        if (d > 3) begin
                            m_gap = t; m_base = pos; m_tot += d;
                        end else if ((t - m_gap) > 20 && (m_tot - t / 256) >= m_min) begin
                            m_to = 0; m_st = 2;
                        end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #1;
        chk(cur_req, done_o, (m_st == 2), "done_o");
        chk(cur_req, busy_o, (m_st != 0), "busy_o");
        chk(cur_req, timed_out_o, m_to, "timed_out_o");
        if (done_o && !saw_done) begin
            saw_done = 1; done_tick = ticks; done_to = timed_out_o;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic us(int e0, int e1);
        @(negedge clk);
        p0 = (p0 + e0) % DEPTH;
        p1 = (p1 + e1) % DEPTH;
        us_tick_i = 1'b1;
        ticks++;
        @(negedge clk);
        us_tick_i = 1'b0;
    endtask

    task automatic begin_wait(int ch, int mn, int lim, bit tick_too);
        @(negedge clk);
        saw_done = 0; done_tick = -1;
        start_i = 1'b1; chan_i = ch[0:0]; min_edges_i = mn[15:0]; timeout_us_i = lim[19:0];
        us_tick_i = tick_too;
        @(negedge clk);
        start_i = 1'b0; us_tick_i = 1'b0; ticks = 0;
    endtask

    task automatic run_out();
        int n = 0;
        while (!saw_done && n < 3000) begin
            us(0, 0);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", busy_o, 0, "busy after reset");
        chk("R1", done_o, 0, "done after reset");
        chk("R1", timed_out_o, 0, "flag after reset");

        // R4 / R3: zero minimum, edges present, limit 5 -> strobe 6
        cur_req = "R4";
        begin_wait(0, 0, 5, 0);
        for (int i = 0; i < 5; i++) us(8, 0);
        run_out();
        chk("R3", done_tick, 6, "timeout strobe");
        chk("R4", done_to, 1, "zero minimum ends on timeout");

        // R9: flag held after done
        cur_req = "R9";
        repeat (5) @(negedge clk);
        chk("R9", timed_out_o, 1, "flag held");
        chk("R9", done_o, 0, "done single cycle");

        // R2 / R6: burst of 20, strobe in accept cycle not counted
        cur_req = "R2";
        begin_wait(0, 10, 1000, 1);
        chk("R2", busy_o, 1, "busy after accept");
        chk("R9", timed_out_o, 0, "flag cleared by start");
        cur_req = "R6";
        for (int i = 0; i < 4; i++) us(5, 0);
        run_out();
        chk("R6", done_tick, 25, "burst end strobe");
        chk("R6", done_to, 0, "burst end flag");

        // R5: advance of exactly 3 is not activity
        cur_req = "R5";
        begin_wait(0, 1, 40, 0);
        us(3, 0);
        run_out();
        chk("R5", done_tick, 41, "three edges ignored");
        chk("R5", done_to, 1, "three edges flag");
        begin_wait(0, 1, 40, 0);
        us(2, 0); us(2, 0);
        run_out();
        chk("R5", done_tick, 23, "accumulated four edges");
        chk("R5", done_to, 0, "accumulated flag");

        // R7: late burst and noise allowance
        cur_req = "R7";
        begin_wait(0, 5, 400, 0);
        for (int i = 0; i < 299; i++) us(0, 0);
        us(6, 0);
        run_out();
        chk("R7", done_tick, 321, "late burst meets minimum");
        chk("R7", done_to, 0, "late burst flag");
        begin_wait(0, 6, 400, 0);
        for (int i = 0; i < 299; i++) us(0, 0);
        us(6, 0);
        run_out();
        chk("R7", done_tick, 401, "allowance defeats burst");
        chk("R7", done_to, 1, "allowance flag");

        // R8 / R11: wrap on channel 1, noise on channel 0
        cur_req = "R11";
        @(negedge clk); p1 = 955;
        begin_wait(1, 10, 500, 0);
        for (int i = 0; i < 3; i++) us(20, 0);
        cur_req = "R8";
        us(0, 10);
        run_out();
        chk("R8", p1, 5, "ring wrapped");
        chk("R8", done_tick, 25, "wrapped advance counted");
        chk("R11", done_to, 0, "other channel ignored");

        // R10: restart mid-wait ignored
        cur_req = "R10";
        begin_wait(0, 2, 30, 0);
        us(0, 0);
        @(negedge clk);
        start_i = 1'b1; chan_i = 1'b1; min_edges_i = 16'd0; timeout_us_i = 20'd5;
        @(negedge clk);
        start_i = 1'b0;
        run_out();
        chk("R10", done_tick, 31, "restart ignored");

        // R12: both conditions on one strobe
        cur_req = "R12";
        begin_wait(0, 1, 21, 0);
        us(5, 0);
        run_out();
        chk("R12", done_tick, 22, "coincident strobe");
        chk("R12", done_to, 1, "timeout wins");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule